// File: doc/BRIEF.md
# Framebuffer Control and Status Register File

This block is the small register window of a framebuffer controller. It holds a control byte, a status byte and fourteen general storage bytes that the cursor and video-timing logic elsewhere on the chip pick up. It also turns a frame-end pulse into a level interrupt. Software reaches it through a byte-wide register port: a write strobe with address and data, and a read path that returns the addressed byte in the same cycle.

At every frame-end pulse, with bit 7 of the control byte set, the block latches a sticky pending flag and raises its interrupt output. Software acknowledges by writing any value to the status byte. A status read merges the pending flag with fixed board-identification bits: a monitor sense code and a colour-board flag.

Top module: `fbctl_regs`

## Requirements
- R1: A write to offset 0x10 stores all 8 data bits in the control byte, and a read of 0x10 returns that byte.
- R2: A frame-end pulse while control bit 7 is 0 leaves the pending flag clear and the interrupt low.
- R3: A frame-end pulse sampled at a clock edge while control bit 7 is 1 sets the pending flag and drives `irq` high from that edge onward.
- R4: A read of offset 0x11 returns the pending flag in bit 7, ORed with the constant 0x61 (sense code in bits 6:5 = 2'b11, colour flag in bit 0 = 1), so it reads 0x61 when idle and 0xE1 when pending.
- R5: Any write to offset 0x11 clears the pending flag and drops `irq` at that edge, whatever the write data.
- R6: A frame-end pulse with interrupts enabled in the same cycle as a status write leaves the pending flag set, so the new event is kept.
- R7: Offsets 0x12 to 0x1F are independent storage bytes. Each one reads back the last value written to it.
- R8: Reads of offsets 0x00 to 0x0F return 0. Writes to them change neither the control byte, the status byte nor any storage byte.
- R9: The pending flag is sticky. Clearing control bit 7 afterwards does not clear it.
- R10: Synchronous reset (active high) drives `irq` low and clears the control byte, the pending flag and every storage byte.
- R11: `irq` is a registered level that always equals status bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the addressed byte |
| addr | input | ADDR_W (5) | Byte offset inside the register window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| frame_end | input | 1 | One-cycle pulse at the end of each frame |
| irq | output | 1 | Level interrupt, high while an event is pending |

## Verification
The bench builds the block with its default parameters: a 5-bit address, which gives the full 32-byte window, sense code 2'b11 and the colour flag set. These values reach every offset class: the dead lower half, the control and status bytes, and both ends of the storage range. They also fix the status constant at 0x61, so each status read is compared against an exact byte. The directed cases cover the cycle where an acknowledge and a new frame event meet, and the sticky flag surviving a disable.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;

    localparam int DW = 8;

    // Offsets whose position other logic depends on
    localparam logic [7:0] OFS_CTRL     = 8'h10;
    localparam logic [7:0] OFS_STAT     = 8'h11;
    localparam logic [7:0] OFS_STORE_LO = 8'h12;

    localparam int IRQ_EN_BIT  = 7;
    localparam int PEND_BIT    = 7;

    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_CTRL  = 2'd1,
        K_STAT  = 2'd2,
        K_STORE = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic            wr;
        reg_kind_e       kind;
        logic [DW-1:0]   data;
    } bus_req_t;

    function automatic reg_kind_e decode(input logic [7:0] ofs);
        if (ofs == OFS_CTRL)           return K_CTRL;
        else if (ofs == OFS_STAT)      return K_STAT;
        else if (ofs >= OFS_STORE_LO)  return K_STORE;
        else                           return K_NONE;
    endfunction

    function automatic logic [DW-1:0] status_byte(input logic pend,
                                                  input logic [1:0] sense,
                                                  input logic color);
        status_byte = {pend, sense, 4'b0000, color};
    endfunction

endpackage

// File: rtl/fbctl_irq.sv
module fbctl_irq
    import fbctl_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  bus_req_t       req,
    input  logic           frame_end,
    output logic [DW-1:0]  ctrl_q,
    output logic           pend_q,
    output logic           irq_q
);
    logic ctrl_wr;
    logic stat_wr;
    logic set_evt;
    logic pend_d;

    assign ctrl_wr = req.wr && (req.kind == K_CTRL);
    assign stat_wr = req.wr && (req.kind == K_STAT);
    assign set_evt = frame_end && ctrl_q[IRQ_EN_BIT];
    // a new event outranks an acknowledge in the same cycle
    assign pend_d  = (pend_q && !stat_wr) || set_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= req.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            irq_q  <= pend_d;
        end
    end
endmodule

// File: rtl/fbctl_store.sv
module fbctl_store
    import fbctl_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [ADDR_W-1:0] addr,
    output logic [DW-1:0]     rd_byte
);
    localparam int LO = int'(OFS_STORE_LO);
    localparam int NB = (1 << ADDR_W) - LO;

    logic [DW-1:0] bytes_q [NB];

    for (genvar i = 0; i < NB; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                bytes_q[i] <= '0;
            end else if (req.wr && req.kind == K_STORE && addr == ADDR_W'(LO + i)) begin
                bytes_q[i] <= req.data;
            end
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NB; i++) begin
            if (addr == ADDR_W'(LO + i)) rd_byte = bytes_q[i];
        end
    end
endmodule

// File: rtl/fbctl_rdmux.sv
module fbctl_rdmux
    import fbctl_pkg::*;
#(
    parameter logic [1:0] SENSE = 2'b11,
    parameter logic       COLOR = 1'b1
) (
    input  reg_kind_e      kind,
    input  logic [DW-1:0]  ctrl_q,
    input  logic           pend_q,
    input  logic [DW-1:0]  store_byte,
    output logic [DW-1:0]  rdata
);
    always_comb begin
        unique case (kind)
            K_CTRL:  rdata = ctrl_q;
            K_STAT:  rdata = status_byte(pend_q, SENSE, COLOR);
            K_STORE: rdata = store_byte;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
    import fbctl_pkg::*;
#(
    parameter int         ADDR_W = 5,
    parameter logic [1:0] SENSE  = 2'b11,
    parameter logic       COLOR  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              frame_end,
    output logic              irq
);
    bus_req_t      req;
    logic [DW-1:0] ctrl_q;
    logic          pend_q;
    logic [DW-1:0] store_byte;

    assign req.wr   = wr_en;
    assign req.kind = decode(8'(addr));
    assign req.data = wdata;

    fbctl_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .frame_end (frame_end),
        .ctrl_q    (ctrl_q),
        .pend_q    (pend_q),
        .irq_q     (irq)
    );

    fbctl_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .addr    (addr),
        .rd_byte (store_byte)
    );

    fbctl_rdmux #(.SENSE(SENSE), .COLOR(COLOR)) u_rdmux (
        .kind       (req.kind),
        .ctrl_q     (ctrl_q),
        .pend_q     (pend_q),
        .store_byte (store_byte),
        .rdata      (rdata)
    );
endmodule

// File: rtl/fbctl_regs_chk.sv
module fbctl_regs_chk #(
    parameter int         ADDR_W = 5,
    parameter logic [1:0] SENSE  = 2'b11,
    parameter logic       COLOR  = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic              frame_end,
    input logic              irq,
    input logic [7:0]        ctrl_q,
    input logic              pend_q
);
    logic stat_w;
    assign stat_w = wr_en && (8'(addr) == 8'h11);

    a_r1_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && 8'(addr) == 8'h10) |=> (ctrl_q == $past(wdata)));

    a_r2_no_event_when_off: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && !ctrl_q[7]) |=> !irq);

    a_r3_event_sets: assert property (@(posedge clk) disable iff (rst)
        (frame_end && ctrl_q[7]) |=> irq);

    a_r4_status_const: assert property (@(posedge clk) disable iff (rst)
        (8'(addr) == 8'h11) |-> (rdata[6:0] == {SENSE, 4'b0000, COLOR} && rdata[7] == pend_q));

    a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_w && !(frame_end && ctrl_q[7])) |=> !irq);

    a_r8_low_half_zero: assert property (@(posedge clk) disable iff (rst)
        (8'(addr) < 8'h10) |-> (rdata == 8'h00));

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !stat_w) |=> irq);

    a_r10_reset: assert property (@(posedge clk)
        rst |=> (!irq && ctrl_q == 8'h00));

    a_r11_irq_tracks: assert property (@(posedge clk) disable iff (rst)
        irq == pend_q);
endmodule

bind fbctl_regs fbctl_regs_chk #(.ADDR_W(ADDR_W), .SENSE(SENSE), .COLOR(COLOR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .frame_end (frame_end),
    .irq       (irq),
    .ctrl_q    (ctrl_q),
    .pend_q    (pend_q)
);

// File: tb/fbctl_regs_tb.sv
module fbctl_regs_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       frame_end = 1'b0;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    fbctl_regs u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .frame_end(frame_end), .irq(irq)
    );

    // op: 0 write, 1 read-and-compare, 2 frame pulse
    typedef struct packed {
        logic [1:0] op;
        logic [3:0] req;
        logic [4:0] a;
        logic [7:0] d;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 4'd1,  5'h10, 8'h5A},   // R1
        '{2'd1, 4'd1,  5'h10, 8'h5A},
        '{2'd1, 4'd4,  5'h11, 8'h61},   // R4 idle
        '{2'd2, 4'd2,  5'h00, 8'h00},   // R2 frame with bit 7 clear
        '{2'd1, 4'd2,  5'h11, 8'h61},
        '{2'd0, 4'd3,  5'h10, 8'h80},   // R3 enable
        '{2'd2, 4'd3,  5'h00, 8'h00},
        '{2'd1, 4'd3,  5'h11, 8'hE1},
        '{2'd0, 4'd9,  5'h10, 8'h00},   // R9 disable keeps pending
        '{2'd1, 4'd9,  5'h11, 8'hE1},
        '{2'd0, 4'd5,  5'h11, 8'hFF},   // R5 ack, data ignored
        '{2'd1, 4'd5,  5'h11, 8'h61},
        '{2'd0, 4'd7,  5'h12, 8'h11},   // R7 storage
        '{2'd0, 4'd7,  5'h1F, 8'hF1},
        '{2'd0, 4'd7,  5'h14, 8'h3C},
        '{2'd1, 4'd7,  5'h12, 8'h11},
        '{2'd1, 4'd7,  5'h1F, 8'hF1},
        '{2'd1, 4'd7,  5'h14, 8'h3C},
        '{2'd1, 4'd7,  5'h13, 8'h00},
        '{2'd0, 4'd8,  5'h05, 8'hAA},   // R8 dead offsets
        '{2'd0, 4'd8,  5'h0F, 8'hFF},
        '{2'd1, 4'd8,  5'h05, 8'h00},
        '{2'd1, 4'd8,  5'h00, 8'h00},
        '{2'd1, 4'd8,  5'h10, 8'h00},
        '{2'd1, 4'd8,  5'h11, 8'h61},
        '{2'd1, 4'd8,  5'h12, 8'h11},
        '{2'd1, 4'd8,  5'h1F, 8'hF1}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic do_frame();
        @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        check("R10 irq after reset", {7'b0, irq}, 8'h00);
        do_read(5'h10, v); check("R10 ctrl after reset", v, 8'h00);
        do_read(5'h11, v); check("R10 status after reset", v, 8'h61);
        do_read(5'h1F, v); check("R10 storage after reset", v, 8'h00);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: do_write(VEC[i].a, VEC[i].d);
                2'd1: begin
                    do_read(VEC[i].a, v);
                    checks++;
                    if (v !== VEC[i].d) begin
                        fails++;
                        $display("FAIL R%0d vector %0d actual=%02h expected=%02h",
                                 VEC[i].req, i, v, VEC[i].d);
                    end
                end
                default: do_frame();
            endcase
        end

        // R3 / R11: irq follows the event, equals status bit 7
        do_write(5'h10, 8'h80);
        check("R11 irq idle", {7'b0, irq}, 8'h00);
        do_frame();
        check("R3 irq after enabled frame", {7'b0, irq}, 8'h01);
        do_read(5'h11, v); check("R11 irq equals status bit 7", {7'b0, irq}, {7'b0, v[7]});

        // R6: ack and new event in the same cycle keeps pending
        @(negedge clk);
        wr_en = 1'b1; addr = 5'h11; wdata = 8'h00; frame_end = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; frame_end = 1'b0;
        check("R6 irq after ack+event", {7'b0, irq}, 8'h01);
        do_read(5'h11, v); check("R6 status after ack+event", v, 8'hE1);

        // R5: plain ack drops irq
        do_write(5'h11, 8'h80);
        check("R5 irq after ack", {7'b0, irq}, 8'h00);

        // R10: reset clears everything from a loaded state
        do_write(5'h10, 8'hC3);
        do_write(5'h16, 8'h77);
        do_frame();
        check("R10 pre-reset irq", {7'b0, irq}, 8'h01);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R10 irq cleared", {7'b0, irq}, 8'h00);
        do_read(5'h10, v); check("R10 ctrl cleared", v, 8'h00);
        do_read(5'h11, v); check("R10 status cleared", v, 8'h61);
        do_read(5'h16, v); check("R10 storage cleared", v, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R0 watchdog actual=timeout expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule